// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block watches the synchronized receive line of a UART and reports two kinds of idle condition as sticky flags. Each flag also has an interrupt pulse. The receive-timeout flag reports that received data is waiting in the receive FIFO and that the line has been quiet for a programmable number of bit periods since the last start edge. The line-timeout flag reports that no new character has begun for one full character period. It does not depend on whether the FIFO holds anything.

Idle time is counted from the oversampling tick, which runs at sixteen times the baud rate, so both timeouts scale with the configured baud rate. A start edge is a falling transition on the receive line, and every start edge restarts both idle timers. After a flag has fired, its timer stays disarmed until the next start edge. Software clears each flag by pulsing its write-one-to-clear input. All pins are plain control and status signals. No data passes through the block, so it has no handshake.

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset both flags and both interrupt pulses are low, and neither flag sets while no start edge has been seen since reset.
- R2: A high-to-low transition of `rx_line` between two consecutive clock edges is a start edge, and it restarts both idle timers from zero.
- R3: With `fifo_level` non-zero, `rxto_flag` becomes visible exactly 16*`rxto_sel` oversampling ticks after the clock edge that registered the start edge.
- R4: An `rxto_sel` of 0 disables the receive timeout, so `rxto_flag` never sets.
- R5: While `fifo_level` is zero the receive-timeout count is held at zero. Once the FIFO is non-empty again, a full 16*`rxto_sel` ticks must pass before the flag sets.
- R6: `lto_flag` sets 16*C ticks after the start edge. C = 1 + (5 + `data_len`) + `parity_en` + (`two_stop` ? 2 : 1), where `data_len` 0..3 encodes 5..8 data bits.
- R7: The line timeout behaves the same whether `fifo_level` is zero or not.
- R8: Each flag stays set until a one is written to its clear input. After a clear it does not set again until a new start edge has occurred.
- R9: When a flag rises and its enable input is high, its interrupt output pulses high for exactly one cycle, in the same cycle the flag first reads high. When the enable input is low, no pulse occurs.
- R10: The timers advance only on clock edges where `os_tick` is high, so slowing the tick stretches both timeouts in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| rx_line | input | 1 | Synchronized receive line, idle high |
| fifo_level | input | LVL_W | Receive FIFO occupancy |
| rxto_sel | input | SEL_W | Receive timeout in bit periods, 0 = off |
| data_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Character includes a parity bit |
| two_stop | input | 1 | Character has two stop bits |
| rxto_clr | input | 1 | Write-one-to-clear for the receive-timeout flag |
| lto_clr | input | 1 | Write-one-to-clear for the line-timeout flag |
| rxto_ie | input | 1 | Receive-timeout interrupt enable |
| lto_ie | input | 1 | Line-timeout interrupt enable |
| rxto_flag | output | 1 | Sticky receive-timeout flag |
| lto_flag | output | 1 | Sticky line-timeout flag |
| rxto_irq | output | 1 | One-cycle receive-timeout interrupt pulse |
| lto_irq | output | 1 | One-cycle line-timeout interrupt pulse |

## Verification
The bench counts the exact number of cycles from the registered start edge to each flag, so an off-by-one in the sub-bit counter or in the character-length sum shows up as a wrong count. One test makes the FIFO non-empty partway through the idle period. A design that lets the count run while the FIFO is empty fires that timeout early. A second start edge in mid-count catches timers that are never restarted, because they fire relative to the first edge. The bench also clears a flag and then waits with no start edge. A design that stays armed after firing would set the flag again during that wait and raise a second interrupt.

// File: rtl/uart_idle_pkg.sv
`timescale 1ns/1ps
package uart_idle_pkg;
  // Character length in bit periods: start + data + parity + stop.
  function automatic logic [4:0] char_bits(input logic [1:0] dlen,
                                           input logic par,
                                           input logic stop2);
    char_bits = 5'd1 + (5'd5 + {3'd0, dlen}) + {4'd0, par} + (stop2 ? 5'd2 : 5'd1);
  endfunction
endpackage

// File: rtl/uart_rx_edge_detect.sv
`timescale 1ns/1ps
module uart_rx_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic start_edge
);
  logic rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_line;
  end

  assign start_edge = rx_q & ~rx_line;

  // R2: a falling edge cannot be registered twice in a row
  p_edge_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_edge |=> !start_edge);
endmodule

// File: rtl/uart_idle_timer.sv
`timescale 1ns/1ps
module uart_idle_timer #(
  parameter int OSR   = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic             armed;
  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] bits_q;
  logic             frozen, bit_done;
  logic [CNT_W:0]   bits_nxt;

  always_comb begin
    frozen   = hold || (limit == '0);
    bit_done = armed && !restart && !frozen && tick && (sub_q == SUB_LAST);
    bits_nxt = {1'b0, bits_q} + 1'b1;
    expire   = bit_done && (bits_nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      sub_q  <= '0;
      bits_q <= '0;
    end else if (restart) begin
      armed  <= 1'b1;
      sub_q  <= '0;
      bits_q <= '0;
    end else if (frozen) begin
      sub_q  <= '0;
      bits_q <= '0;
    end else if (armed && tick) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (expire) begin
          armed  <= 1'b0;
          bits_q <= '0;
        end else begin
          bits_q <= bits_nxt[CNT_W-1:0];
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R10: without a tick the sub-bit phase does not move
  p_sub_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !frozen) |=> $stable(sub_q));
  // R2: a start edge leaves the timer armed at zero
  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (armed && sub_q == '0 && bits_q == '0));
  // R5: hold pins the count at zero
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> (sub_q == '0 && bits_q == '0));
endmodule

// File: rtl/uart_idle_flag.sv
`timescale 1ns/1ps
module uart_idle_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= set | (flag & ~clr);
      irq  <= set & ~flag & ie;
    end
  end

  // R9: interrupt is a single-cycle pulse
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R9: a pulse only accompanies a set flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R8: flag holds until cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R8: a clear without a new set drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/uart_idle_timeout.sv
`timescale 1ns/1ps
module uart_idle_timeout #(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int SEL_W      = 4,
  parameter int CNT_W      = 5,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rx_line,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [SEL_W-1:0] rxto_sel,
  input  logic [1:0]       data_len,
  input  logic             parity_en,
  input  logic             two_stop,
  input  logic             rxto_clr,
  input  logic             lto_clr,
  input  logic             rxto_ie,
  input  logic             lto_ie,
  output logic             rxto_flag,
  output logic             lto_flag,
  output logic             rxto_irq,
  output logic             lto_irq
);
  import uart_idle_pkg::*;

  logic             start_edge;
  logic             fifo_empty;
  logic [CNT_W-1:0] rxto_limit, lto_limit;
  logic             rxto_exp, lto_exp;

  assign fifo_empty = (fifo_level == '0);
  assign rxto_limit = CNT_W'(rxto_sel);
  assign lto_limit  = CNT_W'(char_bits(data_len, parity_en, two_stop));

  uart_rx_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .start_edge(start_edge)
  );

  uart_idle_timer #(.OSR(OSR), .CNT_W(CNT_W)) u_rxto_tmr (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .restart(start_edge),
    .hold(fifo_empty), .limit(rxto_limit), .expire(rxto_exp)
  );

  uart_idle_timer #(.OSR(OSR), .CNT_W(CNT_W)) u_lto_tmr (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .restart(start_edge),
    .hold(1'b0), .limit(lto_limit), .expire(lto_exp)
  );

  uart_idle_flag u_rxto_flag (
    .clk(clk), .rst_n(rst_n), .set(rxto_exp), .clr(rxto_clr), .ie(rxto_ie),
    .flag(rxto_flag), .irq(rxto_irq)
  );

  uart_idle_flag u_lto_flag (
    .clk(clk), .rst_n(rst_n), .set(lto_exp), .clr(lto_clr), .ie(lto_ie),
    .flag(lto_flag), .irq(lto_irq)
  );

  // R3: receive timeout only rises while the FIFO held data
  p_rxto_fifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxto_flag) |-> ($past(fifo_level) != '0));
  // R4: a zero selection never yields a receive timeout
  p_rxto_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxto_flag) |-> ($past(rxto_sel) != '0));
endmodule

// File: tb/tb_uart_idle_timeout.sv
`timescale 1ns/1ps
module tb_uart_idle_timeout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b1;
  logic tick_slow = 1'b0;
  logic rx_line = 1'b1;
  logic [4:0] fifo_level = '0;
  logic [3:0] rxto_sel = 4'd4;
  logic [1:0] data_len = 2'd3;
  logic parity_en = 1'b0, two_stop = 1'b0;
  logic rxto_clr = 1'b0, lto_clr = 1'b0;
  logic rxto_ie = 1'b1, lto_ie = 1'b1;
  logic rxto_flag, lto_flag, rxto_irq, lto_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) os_tick = tick_slow ? ~os_tick : 1'b1;

  uart_idle_timeout dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .fifo_level(fifo_level), .rxto_sel(rxto_sel), .data_len(data_len),
    .parity_en(parity_en), .two_stop(two_stop), .rxto_clr(rxto_clr),
    .lto_clr(lto_clr), .rxto_ie(rxto_ie), .lto_ie(lto_ie),
    .rxto_flag(rxto_flag), .lto_flag(lto_flag), .rxto_irq(rxto_irq), .lto_irq(lto_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_both();
    @(negedge clk); rxto_clr = 1'b1; lto_clr = 1'b1;
    @(negedge clk); rxto_clr = 1'b0; lto_clr = 1'b0;
  endtask

  task automatic send_edge();
    @(negedge clk); rx_line = 1'b0;
    @(negedge clk); rx_line = 1'b1;
  endtask

  // Counts edges after the registered start edge; k is the edge index.
  task automatic run_window(input int cycles, input int fifo_on_at, input int reedge_at,
                            output int rx_at, output int lt_at,
                            output int rx_irq_at, output int lt_irq_at,
                            output int rx_irqs, output int lt_irqs);
    rx_at = -1; lt_at = -1; rx_irq_at = -1; lt_irq_at = -1; rx_irqs = 0; lt_irqs = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      if (rxto_flag && rx_at < 0) rx_at = k;
      if (lto_flag && lt_at < 0) lt_at = k;
      if (rxto_irq) begin rx_irqs++; if (rx_irq_at < 0) rx_irq_at = k; end
      if (lto_irq) begin lt_irqs++; if (lt_irq_at < 0) lt_irq_at = k; end
      if (k == fifo_on_at) fifo_level = 5'd3;
      if (k == reedge_at) rx_line = 1'b0;
      if (k == reedge_at + 1) rx_line = 1'b1;
    end
  endtask

  task automatic t_reset();
    int a, b, c, d, e, f;
    chk(!rxto_flag && !lto_flag && !rxto_irq && !lto_irq, "R1 reset outputs", rxto_flag + lto_flag, 0);
    fifo_level = 5'd2;
    run_window(300, -1, -1, a, b, c, d, e, f);
    chk(a < 0 && b < 0, "R1 no flag without start edge", a + b, -2);
  endtask

  task automatic t_basic();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd3; rxto_sel = 4'd4; data_len = 2'd3;
    parity_en = 0; two_stop = 0;
    send_edge();
    run_window(300, -1, -1, a, b, c, d, e, f);
    chk(a == 64, "R3 rx timeout 4 bits", a, 64);
    chk(b == 160, "R6 line timeout 8N1", b, 160);
    chk(c == a && e == 1, "R9 rx irq single pulse", e, 1);
    chk(d == b && f == 1, "R9 line irq single pulse", f, 1);
  endtask

  task automatic t_disabled();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd3; rxto_sel = 4'd0;
    send_edge();
    run_window(300, -1, -1, a, b, c, d, e, f);
    chk(a < 0, "R4 sel 0 disables rx timeout", a, -1);
    chk(b == 160, "R4 line timeout unaffected", b, 160);
    rxto_sel = 4'd4;
  endtask

  task automatic t_fifo_hold();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd0; rxto_sel = 4'd4;
    send_edge();
    run_window(300, 40, -1, a, b, c, d, e, f);
    chk(a == 104, "R5 count held while fifo empty", a, 104);
    chk(b == 160, "R7 line timeout ignores fifo", b, 160);
    clear_both(); fifo_level = 5'd0;
    send_edge();
    run_window(300, -1, -1, a, b, c, d, e, f);
    chk(a < 0, "R5 empty fifo blocks rx timeout", a, -1);
    chk(b == 160, "R7 line timeout with empty fifo", b, 160);
  endtask

  task automatic t_frames();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd1; rxto_sel = 4'd15;
    data_len = 2'd0; parity_en = 1; two_stop = 1;
    send_edge();
    run_window(300, -1, -1, a, b, c, d, e, f);
    chk(b == 144, "R6 5 data parity 2 stop", b, 144);
    chk(a == 240 || a < 0, "R3 rx timeout 15 bits", a, 240);
    clear_both(); data_len = 2'd1; parity_en = 0; two_stop = 0;
    send_edge();
    run_window(200, -1, -1, a, b, c, d, e, f);
    chk(b == 128, "R6 6 data no parity 1 stop", b, 128);
    data_len = 2'd3; rxto_sel = 4'd4;
  endtask

  task automatic t_restart();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd3;
    send_edge();
    run_window(300, -1, 50, a, b, c, d, e, f);
    chk(a == 115, "R2 restart delays rx timeout", a, 115);
    chk(b == 211, "R2 restart delays line timeout", b, 211);
  endtask

  task automatic t_sticky();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd3;
    send_edge();
    run_window(170, -1, -1, a, b, c, d, e, f);
    run_window(200, -1, -1, a, b, c, d, e, f);
    chk(rxto_flag && lto_flag && e == 0 && f == 0, "R8 flags stay set", e + f, 0);
    @(negedge clk); rxto_clr = 1'b1;
    @(negedge clk); rxto_clr = 1'b0;
    chk(!rxto_flag && lto_flag, "R8 clear drops only rx flag", rxto_flag, 0);
    run_window(300, -1, -1, a, b, c, d, e, f);
    chk(a < 0 && e == 0, "R8 no re-set without start edge", a, -1);
  endtask

  task automatic t_irq_off();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd3; rxto_ie = 0; lto_ie = 0;
    send_edge();
    run_window(200, -1, -1, a, b, c, d, e, f);
    chk(a == 64 && b == 160 && e == 0 && f == 0, "R9 no irq when disabled", e + f, 0);
    rxto_ie = 1; lto_ie = 1;
  endtask

  task automatic t_slow_tick();
    int a, b, c, d, e, f;
    clear_both(); fifo_level = 5'd3; rxto_sel = 4'd2; tick_slow = 1;
    send_edge();
    run_window(400, -1, -1, a, b, c, d, e, f);
    chk(a == 63 || a == 64, "R10 half-rate tick rx timeout", a, 64);
    chk(b == 319 || b == 320, "R10 half-rate tick line timeout", b, 320);
    tick_slow = 0; rxto_sel = 4'd4;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!rxto_flag && !lto_flag, "R1 outputs in reset", rxto_flag + lto_flag, 0);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_disabled();
    t_fifo_hold();
    t_frames();
    t_restart();
    t_sticky();
    t_irq_off();
    t_slow_tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule